// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block keeps track of which cycle a multi-cycle instruction has reached in a small microcoded processor. On every clock it reads a 2-bit next-cycle control field from the microinstruction now being executed. It also reads a flag from the block-transfer register-list encoder, which goes high once the last selected register of a multiple load or store is being handled. From these two inputs it works out the cycle index that addresses the following microinstruction. The combinational next index goes out to the microcode store, and a registered copy holds the current cycle.

Two of the control encodings branch on the list-done flag. This lets a multi-register transfer stay on one cycle, or fall back to an earlier one, until the list runs out. An end-of-instruction pulse tells the fetch/decode pipeline to load the next opcode. An abort input cancels the instruction and sends the sequencer back to cycle 0 without an end pulse.

Top module: `useq_cycle_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cycle_idx` becomes 0 after that edge (synchronous, active-high reset).
- R2: With control code 0 (end) and `abort` low, `next_cycle` is 0 and `end_instr` is 1.
- R3: With control code 1 (step) and `abort` low, `next_cycle` is `cycle_idx + 1` modulo 2^CYC_W, and `end_instr` is 0, even when the count wraps to 0.
- R4: With control code 2 and `list_done` low, `next_cycle` is 2 and `end_instr` is 0.
- R5: With control code 2 and `list_done` high, `next_cycle` is 3 and `end_instr` is 0.
- R6: With control code 3 and `list_done` low, `next_cycle` is 1 and `end_instr` is 0.
- R7: With control code 3 and `list_done` high, `next_cycle` is 0 and `end_instr` is 1.
- R8: When `abort` is high, `next_cycle` is 0 and `end_instr` is 0, whatever the control code and `list_done`.
- R9: Outside reset, `cycle_idx` takes the value `next_cycle` had in the previous cycle.
- R10: A load-multiple sequence uses the microcode {cycle 0: code 1, cycle 1: code 2, cycle 2: code 2, cycle 3: code 0}, and `list_done` is raised in the transfer cycle (1 or 2) that handles the last register. Such a sequence of N registers takes N+2 cycles and ends with `end_instr` in its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_ctl | input | 2 | Next-cycle control field of the current microinstruction |
| list_done | input | 1 | High when the register list of a block transfer is exhausted |
| abort | input | 1 | Cancels the instruction and forces the next cycle to 0 |
| cycle_idx | output | CYC_W | Current cycle number (registered) |
| next_cycle | output | CYC_W | Cycle number that addresses the next microinstruction |
| end_instr | output | 1 | End-of-instruction pulse for the fetch/decode pipeline |

## Verification
Two functions can fall in the same cycle: an abort, and a normal instruction end (code 0, or code 3 with the list exhausted). An abort can also coincide with any branch. The bench walks the sequencer to every cycle value and applies every combination of control code, list-done and abort there. It requires that an abort always wins, with a zero next cycle and no end pulse. The bench then checks that the registered cycle follows on the next edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // next-cycle control field of a microinstruction
  typedef enum logic [1:0] {
    SQ_END  = 2'd0,  // finish instruction
    SQ_STEP = 2'd1,  // go to following cycle
    SQ_BR23 = 2'd2,  // cycle 2, or 3 once list is exhausted
    SQ_BR1E = 2'd3   // back to cycle 1, or finish once list is exhausted
  } seq_ctl_e;

endpackage

// File: rtl/useq_next_sel.sv
module useq_next_sel
  import useq_pkg::*;
#(
  parameter int CYC_W = 2
) (
  input  logic [CYC_W-1:0] cur_cycle,
  input  seq_ctl_e         ctl,
  input  logic             list_done,
  input  logic             abort,
  output logic [CYC_W-1:0] nxt_cycle,
  output logic             eoi
);

  localparam logic [CYC_W-1:0] CYC_ONE   = CYC_W'(1);
  localparam logic [CYC_W-1:0] CYC_TWO   = CYC_W'(2);
  localparam logic [CYC_W-1:0] CYC_THREE = CYC_W'(3);

  always_comb begin
    nxt_cycle = '0;
    eoi       = 1'b0;
    unique case (ctl)
      SQ_END:  eoi = 1'b1;
      SQ_STEP: nxt_cycle = cur_cycle + CYC_ONE;
      SQ_BR23: nxt_cycle = list_done ? CYC_THREE : CYC_TWO;
      SQ_BR1E: begin
        if (list_done) eoi = 1'b1;
        else           nxt_cycle = CYC_ONE;
      end
      default: ;
    endcase
    // abort overrides every encoding
    if (abort) begin
      nxt_cycle = '0;
      eoi       = 1'b0;
    end
  end

endmodule

// File: rtl/useq_cycle_reg.sv
module useq_cycle_reg #(
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] d,
  output logic [CYC_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/useq_cycle_seq.sv
module useq_cycle_seq
  import useq_pkg::*;
#(
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       seq_ctl,
  input  logic             list_done,
  input  logic             abort,
  output logic [CYC_W-1:0] cycle_idx,
  output logic [CYC_W-1:0] next_cycle,
  output logic             end_instr
);

  seq_ctl_e ctl_e;
  assign ctl_e = seq_ctl_e'(seq_ctl);

  useq_next_sel #(.CYC_W(CYC_W)) u_sel (
    .cur_cycle (cycle_idx),
    .ctl       (ctl_e),
    .list_done (list_done),
    .abort     (abort),
    .nxt_cycle (next_cycle),
    .eoi       (end_instr)
  );

  useq_cycle_reg #(.CYC_W(CYC_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (next_cycle),
    .q   (cycle_idx)
  );

  // R1: synchronous reset clears the cycle
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> cycle_idx == '0);

  // R9: register follows the selected next cycle
  a_r9_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cycle_idx == $past(next_cycle));

  // R2: end encoding
  a_r2_end: assert property (@(posedge clk) disable iff (rst)
    (!abort && seq_ctl == 2'd0) |-> (next_cycle == '0 && end_instr));

  // R3: step never signals an end
  a_r3_step_no_end: assert property (@(posedge clk) disable iff (rst)
    (!abort && seq_ctl == 2'd1) |-> !end_instr);

  // R4 / R5: branch 2/3 stays out of cycles 0 and 1
  a_r5_br23_range: assert property (@(posedge clk) disable iff (rst)
    (!abort && seq_ctl == 2'd2) |-> (next_cycle[1] && !end_instr));

  // R6 / R7: branch back or finish
  a_r7_br1e_end: assert property (@(posedge clk) disable iff (rst)
    (!abort && seq_ctl == 2'd3) |-> (end_instr == list_done));

  // R8: abort wins over everything
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    abort |-> (next_cycle == '0 && !end_instr));

  // R2 / R7: an end always restarts at cycle 0
  a_r7_end_restart: assert property (@(posedge clk) disable iff (rst)
    end_instr |=> cycle_idx == '0);

endmodule

// File: tb/useq_cycle_seq_tb.sv
module useq_cycle_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    seq_ctl = 2'd0;
  logic          list_done = 1'b0;
  logic          abort = 1'b0;
  logic [CW-1:0] cycle_idx;
  logic [CW-1:0] next_cycle;
  logic          end_instr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  useq_cycle_seq #(.CYC_W(CW)) u_dut (
    .clk(clk), .rst(rst), .seq_ctl(seq_ctl), .list_done(list_done),
    .abort(abort), .cycle_idx(cycle_idx), .next_cycle(next_cycle),
    .end_instr(end_instr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // expected {eoi, next} from the requirements
  function automatic int exp_next(int cur, int code, int done, int ab);
    if (ab != 0) return 0;                              // R8
    case (code)
      0: return 4;                                      // R2: eoi, next 0
      1: return (cur + 1) % 4;                          // R3
      2: return (done != 0) ? 3 : 2;                    // R4, R5
      default: return (done != 0) ? 4 : 1;              // R6, R7
    endcase
  endfunction

  function automatic string req_of(int code, int done, int ab);
    if (ab != 0) return "R8";
    case (code)
      0: return "R2";
      1: return "R3";
      2: return (done != 0) ? "R5" : "R4";
      default: return (done != 0) ? "R7" : "R6";
    endcase
  endfunction

  function automatic logic [1:0] ucode_ldm(int cyc);
    case (cyc)
      0: return 2'd1;
      1: return 2'd2;
      2: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // leaves the design at cycle c, at a falling edge
  task automatic go_to(int c);
    @(negedge clk);
    abort = 1'b1; seq_ctl = 2'd0; list_done = 1'b0;
    @(negedge clk);
    abort = 1'b0; seq_ctl = 2'd1;
    repeat (c) @(negedge clk);
  endtask

  task automatic run_ldm(int nregs);
    int remaining;
    int count;
    int cur;
    bit ended;
    go_to(0);
    remaining = nregs;
    count = 0;
    ended = 0;
    while (!ended && count < 64) begin
      cur = int'(cycle_idx);
      seq_ctl = ucode_ldm(cur);
      list_done = ((cur == 1 || cur == 2) && remaining == 1);
      abort = 1'b0;
      #1;
      count++;
      ended = end_instr;
      @(negedge clk);
      if (cur == 1 || cur == 2) remaining--;
    end
    chk($sformatf("R10 ldm n=%0d cycles", nregs), count, nregs + 2);
    chk("R10 ldm restart at 0", int'(cycle_idx), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(cycle_idx), 0);
    rst = 1'b0;

    // sweep every cycle, code, list flag and abort
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 2; a++) begin
            go_to(c);
            chk("R3 reach cycle", int'(cycle_idx), c);
            seq_ctl = k[1:0]; list_done = d[0]; abort = a[0];
            #1;
            e = exp_next(c, k, d, a);
            chk({req_of(k, d, a), " next"}, int'(next_cycle), e % 4);
            chk({req_of(k, d, a), " end"}, int'(end_instr), e / 4);
            @(negedge clk);
            chk("R9 register follows", int'(cycle_idx), e % 4);
          end

    // reset from a nonzero cycle
    go_to(3);
    seq_ctl = 2'd2; list_done = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset from cycle 3", int'(cycle_idx), 0);
    rst = 1'b0;

    run_ldm(1);
    run_ldm(4);
    run_ldm(16);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule